// File: doc/BRIEF.md
# Program Memory Readout Guard

This block stands between a processor core and its two program stores: an on-die ROM and an off-die program memory. For every code-memory access it decides whether the access may reach the on-die ROM, the off-die memory, or neither. The level of the external-only strap pin is captured while the block is in reset and then frozen. A pin that is toggled later therefore cannot move an access from one memory space to the other part-way through an instruction.

A static security configuration bit adds a readout policy. When it is set, no test-mode access may return ROM contents. No table read or immediate-operand read issued by code that was itself fetched off-die may return ROM contents either. Any access kind other than opcode fetch, table read or immediate read is never allowed to treat program memory as data. A refused access selects neither memory. One cycle later the returned byte is forced to zero, the data mask is high, and a one-cycle violation pulse is raised.

Top module: `pmem_guard`

## Requirements
- R1: The external-only pin level is captured on every clock edge while `rst_n` is low and on the first two edges after `rst_n` rises. From then on, changes on the pin have no effect on memory selection.
- R2: The pin is captured whether `secure_cfg` is 0 or 1.
- R3: An access goes to the ROM (`rom_sel`=1) when the captured pin is 0 and `req_addr` < ROM_BYTES. Otherwise it goes to the off-die memory (`ext_sel`=1), unless it is refused. With `req_valid`=0, both selects are 0. The selects are combinational in the same cycle as the request.
- R4: With `secure_cfg`=1 and `test_mode`=1, any access that targets the ROM is refused.
- R5: With `secure_cfg`=1 and `exec_from_ext`=1, a table read (`req_kind`=01) or an immediate read (`req_kind`=10) that targets the ROM is refused.
- R6: An access with `req_kind`=11 (a data use of program memory by any other instruction) is always refused, whatever its target.
- R7: A refused access selects neither memory. On the next cycle `data_mask`=1, `cpu_rdata`=0 and `violation`=1. Each of these lasts one cycle per refused access.
- R8: After an accepted access or an idle cycle, the next cycle has `data_mask`=0, `violation`=0 and `cpu_rdata`=`mem_rdata`.
- R9: With `secure_cfg`=0, neither `test_mode` nor `exec_from_ext` causes a refusal.
- R10: An opcode fetch (`req_kind`=00) into the ROM with `exec_from_ext`=1 is allowed when `test_mode`=0, even with `secure_cfg`=1.
- R11: While in reset, `data_mask` and `violation` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_only_pin | input | 1 | Strap: 1 = all program memory off-die |
| secure_cfg | input | 1 | Static readout-protection enable |
| test_mode | input | 1 | Access issued by a test mode |
| exec_from_ext | input | 1 | Current instruction was fetched off-die |
| req_valid | input | 1 | Code-memory access request |
| req_kind | input | 2 | 00 opcode, 01 table read, 10 immediate read, 11 other |
| req_addr | input | ADDR_W | Code address |
| mem_rdata | input | DATA_W | Byte returned by the selected memory |
| rom_sel | output | 1 | Access goes to the on-die ROM |
| ext_sel | output | 1 | Access goes to the off-die memory |
| data_mask | output | 1 | Returned byte is being forced to zero |
| cpu_rdata | output | DATA_W | Byte passed to the core |
| violation | output | 1 | One-cycle refusal pulse |

## Verification
The selects are combinational, so the bench checks them one time step after it drives the request. The mask, violation and data results come one clock edge later. The bench queues each request's expected refusal and pops it at the following falling edge, before it drives new inputs. It holds the strap pin steady through reset and for several cycles after release, and then toggles it freely. From that point every selection must follow the level held before release.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

  typedef enum logic [1:0] {
    KIND_OPCODE = 2'b00,
    KIND_TABLE  = 2'b01,
    KIND_IMMED  = 2'b10,
    KIND_OTHER  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic to_rom;
    logic to_ext;
    logic refuse;
  } route_t;

endpackage

// File: rtl/pmg_strap_capture.sv
module pmg_strap_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_pin,
  output logic strap_q,
  output logic capture_open
);

  logic [SYNC_STAGES-1:0] rel_q;
  logic [SYNC_STAGES-1:0] rel_d;
  logic                   strap_d;

  always_comb begin
    rel_d = {rel_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= rel_d;
  end

  assign capture_open = ~rel_q[SYNC_STAGES-1];

  always_comb begin
    strap_d = strap_q;
    if (capture_open) strap_d = strap_pin;
  end

  always_ff @(posedge clk) begin
    strap_q <= strap_d;
  end

  p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_open |=> $stable(strap_q));

endmodule

// File: rtl/pmg_policy.sv
module pmg_policy
  import pmg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROM_BYTES = 8192
) (
  input  logic              strap_q,
  input  logic              secure_cfg,
  input  logic              test_mode,
  input  logic              exec_from_ext,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output route_t            route
);

  localparam int ROM_LIMIT_W = ADDR_W + 1;
  localparam logic [ROM_LIMIT_W-1:0] ROM_LIMIT = ROM_LIMIT_W'(ROM_BYTES);

  logic targets_rom;
  logic data_kind;
  logic tm_block;
  logic ext_block;
  logic kind_block;

  always_comb begin
    targets_rom = ~strap_q && ({1'b0, req_addr} < ROM_LIMIT);
    data_kind   = (req_kind == KIND_TABLE) || (req_kind == KIND_IMMED);
    kind_block  = (req_kind == KIND_OTHER);
    tm_block    = secure_cfg && test_mode && targets_rom;
    ext_block   = secure_cfg && exec_from_ext && data_kind && targets_rom;
    route.refuse = req_valid && (kind_block || tm_block || ext_block);
    route.to_rom = req_valid && !route.refuse && targets_rom;
    route.to_ext = req_valid && !route.refuse && !targets_rom;
  end

endmodule

// File: rtl/pmg_response.sv
module pmg_response #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refuse,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              data_mask,
  output logic              violation,
  output logic [DATA_W-1:0] cpu_rdata
);

  logic mask_q, mask_d;
  logic viol_q, viol_d;

  always_comb begin
    mask_d = refuse;
    viol_d = refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      viol_q <= viol_d;
    end
  end

  assign data_mask = mask_q;
  assign violation = viol_q;
  assign cpu_rdata = mask_q ? '0 : mem_rdata;

  p_masked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_mask |-> (cpu_rdata == '0));

  p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_mask |-> (cpu_rdata == mem_rdata));

endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
  import pmg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int ROM_BYTES   = 8192,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_only_pin,
  input  logic              secure_cfg,
  input  logic              test_mode,
  input  logic              exec_from_ext,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rom_sel,
  output logic              ext_sel,
  output logic              data_mask,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              violation
);

  logic   strap_q;
  logic   capture_open;
  route_t route;

  pmg_strap_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_pin    (ext_only_pin),
    .strap_q      (strap_q),
    .capture_open (capture_open)
  );

  pmg_policy #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_policy (
    .strap_q       (strap_q),
    .secure_cfg    (secure_cfg),
    .test_mode     (test_mode),
    .exec_from_ext (exec_from_ext),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .req_addr      (req_addr),
    .route         (route)
  );

  pmg_response #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .refuse    (route.refuse),
    .mem_rdata (mem_rdata),
    .data_mask (data_mask),
    .violation (violation),
    .cpu_rdata (cpu_rdata)
  );

  assign rom_sel = route.to_rom;
  assign ext_sel = route.to_ext;

  p_test_no_rom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_cfg && test_mode) |-> !rom_sel);

  p_ext_data_no_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_cfg && exec_from_ext &&
     (req_kind == KIND_TABLE || req_kind == KIND_IMMED)) |-> !rom_sel);

  p_other_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == KIND_OTHER) |-> !(rom_sel || ext_sel));

  p_refusal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rom_sel && !ext_sel) |=> (violation && data_mask));

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> $onehot0({rom_sel, ext_sel}) && !rom_sel && !ext_sel);

endmodule

// File: tb/pmem_guard_tb.sv
module pmem_guard_tb;

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int ROM_BYTES = 8192;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ext_only_pin, secure_cfg, test_mode, exec_from_ext;
  logic              req_valid;
  logic [1:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              rom_sel, ext_sel, data_mask, violation;
  logic [DATA_W-1:0] cpu_rdata;

  int compared = 0;
  int mismatched = 0;
  bit strap_model;
  bit pend_q[$];

  always #5 clk = ~clk;

  pmem_guard u_dut (
    .clk(clk), .rst_n(rst_n), .ext_only_pin(ext_only_pin),
    .secure_cfg(secure_cfg), .test_mode(test_mode),
    .exec_from_ext(exec_from_ext), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .mem_rdata(mem_rdata),
    .rom_sel(rom_sel), .ext_sel(ext_sel), .data_mask(data_mask),
    .cpu_rdata(cpu_rdata), .violation(violation)
  );

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit m_rom_target();
    return !strap_model && (int'(req_addr) < ROM_BYTES);
  endfunction

  function automatic bit m_refuse();
    if (!req_valid) return 1'b0;
    if (req_kind == 2'b11) return 1'b1;
    if (m_rom_target() && secure_cfg &&
        (test_mode || (exec_from_ext && req_kind != 2'b00))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string sel_tag();
    if (req_kind == 2'b11 && req_valid) return "R6";
    if (m_refuse() && test_mode) return "R4";
    if (m_refuse()) return "R5";
    if (ext_only_pin != strap_model) return "R1";
    if (secure_cfg && exec_from_ext && req_kind == 2'b00 && m_rom_target()) return "R10";
    if (!secure_cfg && (test_mode || exec_from_ext)) return "R9";
    return "R3";
  endfunction

  // one cycle: at negedge check registered results, drive, check selects
  task automatic step(bit v, bit [1:0] k, bit [ADDR_W-1:0] a, bit tm, bit xo,
                      bit pin, bit [DATA_W-1:0] md);
    bit exp_ref, exp_rom, exp_ext, prev;
    @(negedge clk);
    mem_rdata = md;
    #1;
    prev = (pend_q.size() > 0) ? pend_q.pop_front() : 1'b0;
    check(prev ? "R7" : "R8", "data_mask", data_mask, prev);
    check(prev ? "R7" : "R8", "violation", violation, prev);
    check(prev ? "R7" : "R8", "cpu_rdata", cpu_rdata, prev ? 0 : md);
    req_valid = v; req_kind = k; req_addr = a; test_mode = tm;
    exec_from_ext = xo; ext_only_pin = pin;
    #1;
    exp_ref = m_refuse();
    exp_rom = v && !exp_ref && m_rom_target();
    exp_ext = v && !exp_ref && !m_rom_target();
    check(sel_tag(), "rom_sel", rom_sel, exp_rom);
    check(sel_tag(), "ext_sel", ext_sel, exp_ext);
    pend_q.push_back(exp_ref);
  endtask

  task automatic do_reset(bit pin, bit sec);
    @(negedge clk);
    rst_n = 1'b0; ext_only_pin = pin; secure_cfg = sec;
    req_valid = 0; req_kind = 0; req_addr = 0; test_mode = 0;
    exec_from_ext = 0; mem_rdata = 8'h5a;
    pend_q.delete();
    repeat (4) @(negedge clk);
    #1;
    check("R11", "data_mask in reset", data_mask, 0);
    check("R11", "violation in reset", violation, 0);
    rst_n = 1'b1;
    strap_model = pin;
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, pin, 8'h11);
  endtask

  task automatic random_run(int n, bit toggle_pin);
    for (int i = 0; i < n; i++) begin
      bit [ADDR_W-1:0] a;
      a = ($urandom % 2) ? ADDR_W'($urandom % ROM_BYTES) : ADDR_W'($urandom);
      step($urandom % 4 != 0, 2'($urandom), a, $urandom % 3 == 0,
           $urandom % 2 == 0, toggle_pin ? 1'($urandom) : ext_only_pin,
           8'($urandom));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset(1'b0, 1'b0);
    // R3 / R9 directed with secure off
    step(1, 2'b01, 16'h0100, 0, 0, 0, 8'hA5);     // R3 ROM table read
    step(1, 2'b01, 16'h2000, 0, 0, 0, 8'h3C);     // R3 boundary: first off-die byte
    step(1, 2'b10, 16'h1FFF, 1, 1, 0, 8'h77);     // R9 last ROM byte, no refusal
    step(1, 2'b11, 16'h0010, 0, 0, 0, 8'hFF);     // R6 refused
    step(1, 2'b11, 16'h0011, 0, 0, 0, 8'hFE);     // R7 back-to-back refusal
    step(0, 2'b00, 16'h0000, 0, 0, 0, 8'h42);     // R8 after refusal
    random_run(400, 1'b1);                        // R1 pin toggles ignored

    // R2: pin captured while secure is set
    do_reset(1'b1, 1'b1);
    step(1, 2'b01, 16'h0004, 1, 1, 0, 8'h99);     // R2 all off-die, test allowed
    random_run(400, 1'b1);

    // secure with on-die ROM enabled
    do_reset(1'b0, 1'b1);
    step(1, 2'b00, 16'h0040, 1, 0, 0, 8'h12);     // R4 opcode in test refused
    step(1, 2'b01, 16'h0040, 0, 1, 0, 8'h34);     // R5 table from off-die code
    step(1, 2'b10, 16'h0041, 0, 1, 0, 8'h56);     // R5 immediate from off-die code
    step(1, 2'b00, 16'h0042, 0, 1, 0, 8'h78);     // R10 branch into ROM allowed
    step(1, 2'b01, 16'h0042, 0, 0, 0, 8'h9A);     // R3 internal table read
    step(1, 2'b01, 16'h4000, 1, 1, 1, 8'hBC);     // R1 pin high ignored, off-die addr
    random_run(600, 1'b1);
    step(0, 2'b00, 16'h0000, 0, 0, 0, 8'h01);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule